// File: doc/BRIEF.md
# Repeating-fraction mantissa adder

This block adds two fractional operands that are already aligned. Each operand is held as a sign, a non-repeating head of fixed width and a repeating tail. The tail is a period of 1 to `PMAX` bits that repeats without end after the head. The bits of the head and of the period are read most significant first.

On a start pulse the block finds the least common multiple of the two period lengths. It then builds each period out to that length, adding one copy per cycle, and adds the operands in a single step. The add uses an end-around carry: the carry out of the tail sum goes back into the tail and is also passed on into the head sum. Opposite signs are handled by taking the complement of the second operand over its full infinite expansion.

Three candidate results are formed: the plain sum, the sum plus one and the complemented sum. One of them is selected from the sign difference and the two carries. The result has the sign, an integer bit, a head, a period and a period length. A normalization stage further on consumes it.

Top module: `rational_mantissa_adder`

## Requirements
- R1: A start pulse taken while idle captures both operands and raises busy. Results appear together with a done pulse that lasts one cycle and comes after busy has dropped. A start pulse that arrives while busy has no effect on the result.
- R2: When the least common multiple of the two period lengths (`a_plen`, `b_plen`) is no more than `EW`, `r_plen` equals that least common multiple and `r_approx` is 0.
- R3: With equal operand signs, the value `r_int + 0.r_fix(r_per repeated)` equals the exact sum of the two magnitudes. `r_sign` equals the common sign.
- R4: The carry out of the extended period sum is added back into the result period and also carried into the head sum. Without this the value check of R3 fails for operands whose periods overflow.
- R5: With different operand signs, the result value equals the magnitude of the difference and `r_int` is 0. `r_sign` is the sign of the operand with the larger magnitude.
- R6: When the least common multiple exceeds `EW`, `r_approx` is 1 and `r_plen` equals `EW`.
- R7: `r_ones` is 1 exactly when the result period is all ones over its `r_plen` bits.
- R8: A result of zero (head, period and integer bit all zero) has `r_sign` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an addition |
| a_sign | input | 1 | Sign of operand A, 1 means negative |
| a_fix | input | FW | Head bits of A |
| a_per | input | PMAX | Period of A in its low `a_plen` bits |
| a_plen | input | LW | Period length of A, 1 to PMAX |
| b_sign | input | 1 | Sign of operand B |
| b_fix | input | FW | Head bits of B |
| b_per | input | PMAX | Period of B in its low `b_plen` bits |
| b_plen | input | LW | Period length of B, 1 to PMAX |
| busy | output | 1 | An addition is in progress |
| done | output | 1 | One-cycle pulse, results valid |
| r_sign | output | 1 | Result sign |
| r_int | output | 1 | Integer bit of the result |
| r_fix | output | FW | Result head |
| r_per | output | EW | Result period in its low `r_plen` bits |
| r_plen | output | RLW | Result period length |
| r_approx | output | 1 | Period was cut to EW bits |
| r_ones | output | 1 | Result period is all ones |

## Verification
The assertions assume that a start pulse is given only while the block is idle. They also assume that each period length lies between 1 and `PMAX`, and that period bits above the stated length may hold anything, because the block masks them.

The bench sweeps every pair of period lengths in a small configuration with four sign and pattern variants each. It drives start only between operations and keeps each length inside its legal range. One directed case raises start in the middle of a run to check that the pulse is ignored.

// File: rtl/rational_mantissa_adder.sv
module rational_mantissa_adder #(
  parameter int FW   = 16,
  parameter int PMAX = 32,
  parameter int EW   = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     a_sign,
  input  logic [FW-1:0]            a_fix,
  input  logic [PMAX-1:0]          a_per,
  input  logic [$clog2(PMAX+1)-1:0] a_plen,
  input  logic                     b_sign,
  input  logic [FW-1:0]            b_fix,
  input  logic [PMAX-1:0]          b_per,
  input  logic [$clog2(PMAX+1)-1:0] b_plen,
  output logic                     busy,
  output logic                     done,
  output logic                     r_sign,
  output logic                     r_int,
  output logic [FW-1:0]            r_fix,
  output logic [EW-1:0]            r_per,
  output logic [$clog2(EW+1)-1:0]  r_plen,
  output logic                     r_approx,
  output logic                     r_ones
);
  localparam int LW  = $clog2(PMAX+1);
  localparam int RLW = $clog2(EW+1);
  localparam int XW  = EW + PMAX;
  localparam int CW  = $clog2(XW+1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_LCM, S_REP, S_ADD} st_t;
  st_t st;

  logic          sa, sb;
  logic [FW-1:0] fa, fb;
  logic [XW-1:0] pa, pb, xa, xb;
  logic [LW-1:0] la, lb;
  logic [CW-1:0] ma, mb;
  logic [RLW-1:0] len;
  logic signed [CW-1:0] ra, rb;
  logic          apx;

  function automatic logic [XW-1:0] low_mask(input logic [LW-1:0] n);
    return ~({XW{1'b1}} << n);
  endfunction

  assign busy = (st != S_IDLE);

  logic [CW-1:0] ova, ovb;
  logic [EW-1:0] ea, eb;
  assign ova = CW'(-ra);
  assign ovb = CW'(-rb);
  assign ea  = EW'(xa >> ova);
  assign eb  = EW'(xb >> ovb);

  logic          sub, pc, fc, neg;
  logic [EW:0]   lmask, pbx, psum, ps, pinc, psel, pfin;
  logic [FW:0]   fsum;
  logic [FW-1:0] ffin;

  assign sub   = sa ^ sb;
  assign lmask = ~({(EW+1){1'b1}} << len);
  assign pbx   = sub ? (~{1'b0, eb} & lmask) : {1'b0, eb};
  assign psum  = {1'b0, ea} + pbx;
  assign pc    = psum[len];
  assign ps    = psum & lmask;
  assign pinc  = (ps + (EW+1)'(pc)) & lmask;
  assign psel  = pc ? pinc : ps;
  assign fsum  = {1'b0, fa} + {1'b0, (sub ? ~fb : fb)} + (FW+1)'(pc);
  assign fc    = fsum[FW];
  assign neg   = sub & ~fc;
  assign pfin  = neg ? (~psel & lmask) : psel;
  assign ffin  = neg ? ~fsum[FW-1:0] : fsum[FW-1:0];

  logic rint, rzero, rsgn;
  assign rint  = ~sub & fc;
  assign rzero = (pfin == '0) && (ffin == '0) && !rint;
  assign rsgn  = rzero ? 1'b0 : ((sub && !fc) ? sb : sa);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0;
      sa <= 1'b0; sb <= 1'b0; fa <= '0; fb <= '0;
      pa <= '0; pb <= '0; xa <= '0; xb <= '0;
      la <= '0; lb <= '0; ma <= '0; mb <= '0;
      len <= '0; ra <= '0; rb <= '0; apx <= 1'b0;
      r_sign <= 1'b0; r_int <= 1'b0; r_fix <= '0; r_per <= '0;
      r_plen <= '0; r_approx <= 1'b0; r_ones <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          sa <= a_sign; sb <= b_sign; fa <= a_fix; fb <= b_fix;
          pa <= XW'(a_per) & low_mask(a_plen);
          pb <= XW'(b_per) & low_mask(b_plen);
          la <= a_plen; lb <= b_plen;
          ma <= CW'(a_plen); mb <= CW'(b_plen);
          xa <= '0; xb <= '0; apx <= 1'b0;
          st <= S_LCM;
        end
        S_LCM: begin
          if (ma == mb) begin
            len <= RLW'(ma); ra <= $signed(ma); rb <= $signed(mb);
            st <= S_REP;
          end else if (ma > CW'(EW) || mb > CW'(EW)) begin
            len <= RLW'(EW); apx <= 1'b1;
            ra <= $signed(CW'(EW)); rb <= $signed(CW'(EW));
            st <= S_REP;
          end else if (ma < mb) ma <= ma + CW'(la);
          else mb <= mb + CW'(lb);
        end
        S_REP: begin
          if (ra > 0) begin
            xa <= (xa << la) | pa;
            ra <= ra - $signed(CW'(la));
          end
          if (rb > 0) begin
            xb <= (xb << lb) | pb;
            rb <= rb - $signed(CW'(lb));
          end
          if (ra <= 0 && rb <= 0) st <= S_ADD;
        end
        S_ADD: begin
          r_sign <= rsgn; r_int <= rint; r_fix <= ffin;
          r_per <= pfin[EW-1:0]; r_plen <= len; r_approx <= apx;
          r_ones <= (pfin == lmask);
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r2_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (r_plen != '0 && r_plen <= RLW'(EW)));
  a_r6_approx_len: assert property (@(posedge clk) disable iff (!rst_n)
    (done && r_approx) |-> (r_plen == RLW'(EW)));
  a_r7_ones_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && r_ones) |-> (r_per != '0));
  a_r8_zero_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (done && r_fix == '0 && r_per == '0 && !r_int) |-> !r_sign);
endmodule

// File: tb/rational_mantissa_adder_bench.sv
module rational_mantissa_adder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 4, PMAX = 8, EW = 32;
  localparam int LW = $clog2(PMAX+1), RLW = $clog2(EW+1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic a_sign = 1'b0, b_sign = 1'b0;
  logic [FW-1:0] a_fix = '0, b_fix = '0;
  logic [PMAX-1:0] a_per = '0, b_per = '0;
  logic [LW-1:0] a_plen = 4'd1, b_plen = 4'd1;
  logic busy, done, r_sign, r_int, r_approx, r_ones;
  logic [FW-1:0] r_fix;
  logic [EW-1:0] r_per;
  logic [RLW-1:0] r_plen;
  int checks = 0, failures = 0, cycles = 0;

  rational_mantissa_adder #(.FW(FW), .PMAX(PMAX), .EW(EW)) u_rational_mantissa_adder (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_sign(a_sign), .a_fix(a_fix), .a_per(a_per), .a_plen(a_plen),
    .b_sign(b_sign), .b_fix(b_fix), .b_per(b_per), .b_plen(b_plen),
    .busy(busy), .done(done), .r_sign(r_sign), .r_int(r_int), .r_fix(r_fix),
    .r_per(r_per), .r_plen(r_plen), .r_approx(r_approx), .r_ones(r_ones));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gcd(input int x, input int y);
    while (y != 0) begin int t = x % y; x = y; y = t; end
    return x;
  endfunction

  function automatic longint extend(input int p, input int l, input int total);
    longint e = 0;
    for (int k = 0; k < total / l; k++) e = (e << l) | longint'(p);
    return e;
  endfunction

  task automatic run(input bit sa, input int fa, input int pa, input int la,
                     input bit sb, input int fb, input int pb, input int lb,
                     input bit disturb, input bit expect_ones);
    int n = 0, lcm;
    longint md, na, nb, ns, got;
    pa = pa & ((1 << la) - 1);
    pb = pb & ((1 << lb) - 1);
    a_sign = sa; a_fix = FW'(fa); a_per = PMAX'(pa); a_plen = LW'(la);
    b_sign = sb; b_fix = FW'(fb); b_per = PMAX'(pb); b_plen = LW'(lb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      check(busy == 1'b1, "R1 busy after start", longint'(busy), 1);
      start = 1'b1; a_fix = ~a_fix; b_per = ~b_per; a_sign = ~a_sign;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && n < 2000) begin @(negedge clk); n++; end
    check(done == 1'b1, "R1 done seen", longint'(done), 1);
    lcm = la * lb / gcd(la, lb);
    if (lcm > EW) begin
      check(r_approx == 1'b1, "R6 approx flag", longint'(r_approx), 1);
      check(r_plen == RLW'(EW), "R6 approx length", longint'(r_plen), EW);
    end else begin
      md = (64'sd1 <<< lcm) - 1;
      na = longint'(fa) * md + extend(pa, la, lcm);
      nb = longint'(fb) * md + extend(pb, lb, lcm);
      ns = (sa ? -na : na) + (sb ? -nb : nb);
      got = ((longint'(r_int) << FW) + longint'(r_fix)) * md + longint'(r_per);
      check(r_approx == 1'b0 && r_plen == RLW'(lcm), "R2 lcm length", longint'(r_plen), lcm);
      if (sa == sb) begin
        check(got == ns * (sa ? -1 : 1), "R3/R4 same-sign value", got, ns * (sa ? -1 : 1));
        check(r_sign == sa || ns == 0, "R3 sign", longint'(r_sign), longint'(sa));
      end else begin
        check(got == (ns < 0 ? -ns : ns), "R5 difference value", got, (ns < 0 ? -ns : ns));
        check(r_int == 1'b0, "R5 no integer bit", longint'(r_int), 0);
        check(r_sign == (ns < 0), "R5/R8 sign", longint'(r_sign), longint'(ns < 0));
      end
      check(r_ones == (longint'(r_per) == md), "R7 ones flag", longint'(r_ones), longint'(longint'(r_per) == md));
      if (expect_ones) check(r_ones == 1'b1, "R7 directed all-ones", longint'(r_ones), 1);
    end
    @(negedge clk);
    check(done == 1'b0, "R1 done one cycle", longint'(done), 0);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R1 reset state", longint'({busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(0, 3, 4'b0101, 4, 0, 2, 4'b1010, 4, 0, 1);
    run(0, 9, 3'b110, 3, 1, 9, 3'b110, 3, 0, 0);
    run(1, 15, 8'hFF, 8, 1, 15, 1, 1, 0, 0);
    run(0, 7, 6'h2B, 6, 1, 2, 4'h9, 4, 1, 0);
    run(0, 1, 7'h55, 7, 0, 1, 8'hA3, 8, 0, 0);
    for (int la = 1; la <= PMAX; la++)
      for (int lb = 1; lb <= PMAX; lb++)
        for (int t = 0; t < 4; t++)
          run(t[0], (la * 3 + t) & 15, la * 29 + lb * 13 + t * 7, la,
              t[1], (lb * 5 + t * 7) & 15, lb * 17 + la * 5 + t * 3, lb, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule